// File: doc/BRIEF.md
# Sample-Stream Trigger Condition Detector

This block watches a stream of signed sample words and raises a one-clock trigger pulse when a programmed condition occurs. Five condition sources are selectable: a threshold crossing, a crossing that must first be armed by an excursion past a hysteresis band, a transition into or out of an interval bounded by two thresholds, every valid sample, and a software request. A slope bit picks the rising or falling direction, or entering or leaving for the interval.

Once a condition is accepted, the block waits a programmable number of sample periods and then fires. After firing it stays blocked for a fixed ten-period dead time, or for the programmed holdoff if that is longer. Conditions that turn up while it is waiting or blocked are dropped. Sample periods are counted on the valid strobe, so the stream may have gaps.

Configuration inputs are meant to be set while the block is held in reset and kept steady while it runs.

Top module: `trig_detect`

## Requirements
- R1: After reset `trig_out` is low and stays low while no condition occurs. Mode codes 5, 6 and 7 never produce a condition.
- R2: In mode 0 (threshold crossing) with `slope`=0, a condition occurs when the previous valid sample is below `thr_hi` and the current one is at or above it. With `slope`=1, the previous sample is at or above and the current one is below. The first valid sample after reset never produces a condition. With zero delay, `trig_out` is high for the cycle after the clock edge that follows the edge capturing the qualifying sample.
- R3: In mode 1 (hysteresis), `slope`=0 arms on a valid sample below `thr_hi - hyst_w` and fires on the next valid sample at or above `thr_hi`. `slope`=1 arms above `thr_hi + hyst_w` and fires below `thr_hi`. Each firing disarms, and without arming no crossing fires.
- R4: In mode 2 (interval), inside means `thr_lo <= sample <= thr_hi`. `slope`=0 fires on an outside-to-inside transition between consecutive valid samples, and `slope`=1 fires on inside-to-outside.
- R5: In mode 3 (immediate), every valid sample is a condition, so the first valid sample after reset fires.
- R6: In mode 4 (software), a one-clock pulse on `sw_trig` is a condition whether or not `smp_valid` is high.
- R7: Clock cycles with `smp_valid` low neither fire nor change the sample history used by modes 0 to 2.
- R8: Every trigger is exactly one clock cycle wide.
- R9: A nonzero `delay` postpones the pulse by exactly `delay` valid strobes after the condition is accepted.
- R10: After a pulse, conditions are dropped for max(10, `holdoff`) sample periods. With `holdoff` below 10 and a condition on every valid sample, pulses are 10 clocks apart.
- R11: With `holdoff` of 10 or more and conditions on every sample, pulses are exactly `holdoff` clocks apart.
- R12: A condition dropped during the blocking period never produces a later pulse.
- R13: Conditions that occur while a delayed trigger is pending are dropped, and the pending pulse keeps its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe; one strobe is one sample period |
| smp_data | input | DW | Two's-complement sample |
| sw_trig | input | 1 | Software trigger request (mode 4) |
| mode | input | 3 | 0 crossing, 1 hysteresis, 2 interval, 3 immediate, 4 software |
| slope | input | 1 | 0 rising/entering, 1 falling/leaving |
| thr_hi | input | DW | Threshold, or upper interval bound (signed) |
| thr_lo | input | DW | Lower interval bound (signed) |
| hyst_w | input | DW | Hysteresis band width (unsigned) |
| holdoff | input | HOLD_W | Blocking length in sample periods, floored at the dead time |
| delay | input | DLY_W | Sample periods from acceptance to pulse |
| trig_out | output | 1 | Single-cycle trigger pulse |

## Verification
The embedded properties compare a registered condition with the current `mode`. They therefore rely on the configuration inputs staying constant between resets, and the bench changes configuration only while `rst_n` is low. The thresholds are widened by two bits before any sum or difference, so no property assumes the caller avoids overflow. Every delay and holdoff in the stimulus is short, so each blocking and waiting window closes well inside a scenario. Gaps in the valid strobe are placed where they shift the pulse by a predictable number of cycles.

// File: rtl/trig_pkg.sv
package trig_pkg;
   typedef enum logic [2:0] {
      TM_EDGE = 3'd0,
      TM_HYST = 3'd1,
      TM_WIN  = 3'd2,
      TM_IMM  = 3'd3,
      TM_SOFT = 3'd4
   } trg_mode_e;

   typedef enum logic [1:0] {
      TS_READY = 2'd0,
      TS_WAIT  = 2'd1,
      TS_BLOCK = 2'd2
   } trg_state_e;
endpackage

// File: rtl/trig_cond.sv
module trig_cond
   import trig_pkg::*;
#(
   parameter int DW       = 14,
   parameter bit WIN_INCL = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 smp_valid,
   input  logic signed [DW-1:0] smp_data,
   input  logic                 sw_trig,
   input  trg_mode_e            mode,
   input  logic                 slope,
   input  logic signed [DW-1:0] thr_hi,
   input  logic signed [DW-1:0] thr_lo,
   input  logic        [DW-1:0] hyst_w,
   output logic                 hit
);
   localparam int EW = DW + 2;

   logic signed [DW-1:0] prev_q;
   logic                 have_q, armed_q, hit_q;
   logic signed [EW-1:0] cur_x, prev_x, hi_x, lo_x, hy_x, arm_lo_x, arm_hi_x;
   logic                 cur_ge, prev_ge, cur_in, prev_in;
   logic                 edge_hit, win_hit, arm_now, hyst_fire, hit_d;

   assign cur_x    = EW'(smp_data);
   assign prev_x   = EW'(prev_q);
   assign hi_x     = EW'(thr_hi);
   assign lo_x     = EW'(thr_lo);
   assign hy_x     = EW'($signed({1'b0, hyst_w}));
   assign arm_lo_x = hi_x - hy_x;
   assign arm_hi_x = hi_x + hy_x;

   assign cur_ge  = (cur_x >= hi_x);
   assign prev_ge = (prev_x >= hi_x);

   generate
      if (WIN_INCL) begin : g_incl
         assign cur_in  = (cur_x >= lo_x) && (cur_x <= hi_x);
         assign prev_in = (prev_x >= lo_x) && (prev_x <= hi_x);
      end else begin : g_excl
         assign cur_in  = (cur_x > lo_x) && (cur_x < hi_x);
         assign prev_in = (prev_x > lo_x) && (prev_x < hi_x);
      end
   endgenerate

   assign edge_hit  = have_q & (slope ? (prev_ge & ~cur_ge) : (~prev_ge & cur_ge));
   assign win_hit   = have_q & (slope ? (prev_in & ~cur_in) : (~prev_in & cur_in));
   assign arm_now   = slope ? (cur_x > arm_hi_x) : (cur_x < arm_lo_x);
   assign hyst_fire = armed_q & (slope ? ~cur_ge : cur_ge);

   always_comb begin
      hit_d = 1'b0;
      case (mode)
         TM_EDGE: hit_d = smp_valid & edge_hit;
         TM_HYST: hit_d = smp_valid & hyst_fire;
         TM_WIN:  hit_d = smp_valid & win_hit;
         TM_IMM:  hit_d = smp_valid;
         TM_SOFT: hit_d = sw_trig;
         default: hit_d = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q  <= '0;
         have_q  <= 1'b0;
         armed_q <= 1'b0;
         hit_q   <= 1'b0;
      end else begin
         hit_q <= hit_d;
         if (smp_valid) begin
            prev_q <= smp_data;
            have_q <= 1'b1;
            if (mode == TM_HYST) armed_q <= hyst_fire ? 1'b0 : (armed_q | arm_now);
            else                 armed_q <= 1'b0;
         end
      end
   end

   assign hit = hit_q;

   // R3: a hysteresis firing needs an arming seen on an earlier sample
   a_r3_hyst_armed_first: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_q && mode == TM_HYST) |-> $past(armed_q));

   // R2: a crossing needs a previous valid sample
   a_r2_edge_has_history: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_q && mode == TM_EDGE) |-> $past(have_q));

   // R7: sample-based conditions only follow a valid strobe
   a_r7_hit_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_q && mode != TM_SOFT) |-> $past(smp_valid));
endmodule

// File: rtl/trig_timer.sv
module trig_timer
   import trig_pkg::*;
#(
   parameter int HOLD_W = 64,
   parameter int DLY_W  = 51,
   parameter int DEAD   = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              hit,
   input  logic [HOLD_W-1:0] holdoff,
   input  logic [DLY_W-1:0]  delay,
   output logic              trig
);
   localparam logic [HOLD_W-1:0] DEAD_V = HOLD_W'(DEAD);

   trg_state_e        st;
   logic [HOLD_W-1:0] bcnt, blk;
   logic [DLY_W-1:0]  dcnt;
   logic              trig_q, open;

   assign blk  = (holdoff < DEAD_V) ? DEAD_V : holdoff;
   assign open = (st == TS_READY) || ((st == TS_BLOCK) && (bcnt == '0));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= TS_READY;
         bcnt   <= '0;
         dcnt   <= '0;
         trig_q <= 1'b0;
      end else begin
         trig_q <= 1'b0;
         case (st)
            TS_WAIT: begin
               if (tick) begin
                  if (dcnt == '0) begin
                     trig_q <= 1'b1;
                     st     <= TS_BLOCK;
                     bcnt   <= blk - HOLD_W'(1);
                  end else begin
                     dcnt <= dcnt - DLY_W'(1);
                  end
               end
            end
            default: begin
               if (open) begin
                  if (hit) begin
                     if (delay == '0) begin
                        trig_q <= 1'b1;
                        st     <= TS_BLOCK;
                        bcnt   <= blk - HOLD_W'(1);
                     end else begin
                        st   <= TS_WAIT;
                        dcnt <= delay - DLY_W'(1);
                     end
                  end else begin
                     st <= TS_READY;
                  end
               end else if (tick) begin
                  bcnt <= bcnt - HOLD_W'(1);
               end
            end
         endcase
      end
   end

   assign trig = trig_q;

   // R8: a pulse never lasts two cycles
   a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      trig_q |=> !trig_q);

   // R10: no pulse while the blocking count is still running
   a_r10_quiet_block: assert property (@(posedge clk) disable iff (!rst_n)
      (st == TS_BLOCK && bcnt != '0) |=> !trig_q);

   // R9: the delay count moves down by one per strobe until it fires
   a_r9_delay_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (st == TS_WAIT && tick && dcnt != '0) |=> (st == TS_WAIT && dcnt == $past(dcnt) - DLY_W'(1)));

   // R13: a pending delay is left only through a pulse
   a_r13_wait_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (st == TS_WAIT && tick && dcnt == '0) |=> trig_q);
endmodule

// File: rtl/trig_detect.sv
module trig_detect
   import trig_pkg::*;
#(
   parameter int DW       = 14,
   parameter int HOLD_W   = 64,
   parameter int DLY_W    = 51,
   parameter int DEAD     = 10,
   parameter bit WIN_INCL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid,
   input  logic [DW-1:0]     smp_data,
   input  logic              sw_trig,
   input  logic [2:0]        mode,
   input  logic              slope,
   input  logic [DW-1:0]     thr_hi,
   input  logic [DW-1:0]     thr_lo,
   input  logic [DW-1:0]     hyst_w,
   input  logic [HOLD_W-1:0] holdoff,
   input  logic [DLY_W-1:0]  delay,
   output logic              trig_out
);
   localparam int DEAD_BITS = $clog2(DEAD + 1);

   generate
      if (DW < 4) begin : g_bad_dw
         $error("trig_detect: DW must be at least 4");
      end
      if (DEAD < 2) begin : g_bad_dead
         $error("trig_detect: DEAD must be at least 2");
      end
      if (HOLD_W < DEAD_BITS) begin : g_bad_hold
         $error("trig_detect: HOLD_W too narrow for DEAD");
      end
      if (DLY_W < 1) begin : g_bad_dly
         $error("trig_detect: DLY_W must be positive");
      end
   endgenerate

   logic hit;

   trig_cond #(.DW(DW), .WIN_INCL(WIN_INCL)) u_cond (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_valid (smp_valid),
      .smp_data  (smp_data),
      .sw_trig   (sw_trig),
      .mode      (trg_mode_e'(mode)),
      .slope     (slope),
      .thr_hi    (thr_hi),
      .thr_lo    (thr_lo),
      .hyst_w    (hyst_w),
      .hit       (hit)
   );

   trig_timer #(.HOLD_W(HOLD_W), .DLY_W(DLY_W), .DEAD(DEAD)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (smp_valid),
      .hit     (hit),
      .holdoff (holdoff),
      .delay   (delay),
      .trig    (trig_out)
   );

   // R1: unused mode codes never lead to a pulse
   a_r1_bad_mode_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (mode > 3'd4 && $past(mode > 3'd4)) |=> !trig_out);
endmodule

// File: tb/trig_detect_bench.sv
module trig_detect_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_valid = 1'b0;
   logic [13:0] smp_data = '0;
   logic        sw_trig = 1'b0;
   logic [2:0]  mode = '0;
   logic        slope = 1'b0;
   logic [13:0] thr_hi = '0, thr_lo = '0, hyst_w = '0;
   logic [63:0] holdoff = '0;
   logic [50:0] delay = '0;
   logic        trig_out;

   int cyc = 0;
   int checks = 0, failures = 0;
   int trig_total = 0, last_trig = -1, prev_trig = -1, dbl = 0;
   bit hi_last = 1'b0;

   trig_detect u_trig_detect (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .sw_trig(sw_trig), .mode(mode), .slope(slope), .thr_hi(thr_hi),
      .thr_lo(thr_lo), .hyst_w(hyst_w), .holdoff(holdoff), .delay(delay),
      .trig_out(trig_out)
   );

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (!rst_n) begin
         hi_last = 1'b0;
      end else begin
         if (trig_out) begin
            if (hi_last) dbl++;
            trig_total++;
            prev_trig = last_trig;
            last_trig = cyc;
         end
         hi_last = trig_out;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic apply(input int m, input int sl, input int hi, input int lo,
                        input int hy, input int ho, input int dl);
      @(negedge clk);
      rst_n = 1'b0; smp_valid = 1'b0; sw_trig = 1'b0;
      mode = 3'(m); slope = sl[0]; thr_hi = 14'(hi); thr_lo = 14'(lo);
      hyst_w = 14'(hy); holdoff = 64'(ho); delay = 51'(dl);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic push(input int v, output int k);
      @(negedge clk);
      smp_data = 14'(v); smp_valid = 1'b1;
      k = cyc + 1;
   endtask

   task automatic pushn(input int v, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         smp_data = 14'(v); smp_valid = 1'b1;
      end
   endtask

   task automatic gap(input int v, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         smp_data = 14'(v); smp_valid = 1'b0;
      end
   endtask

   task automatic t_reset;
      int n0, k;
      apply(3, 0, 0, 0, 0, 0, 0);
      gap(0, 6);
      chk(trig_total == 0 && trig_out == 1'b0, "R1", "pulses after reset", trig_total, 0);
      apply(5, 0, 0, 0, 0, 0, 0);
      n0 = trig_total;
      push(-10, k); pushn(10, 3); push(-10, k); pushn(10, 12);
      chk(trig_total == n0, "R1", "pulses with mode code 5", trig_total - n0, 0);
   endtask

   task automatic t_edge;
      int n0, k;
      apply(0, 0, 0, 0, 0, 0, 0);
      n0 = trig_total;
      push(-50, k); push(50, k); pushn(50, 3);
      chk(trig_total - n0 == 1, "R2", "rising crossing count", trig_total - n0, 1);
      chk(last_trig == k + 1, "R2", "rising crossing cycle", last_trig, k + 1);
      apply(0, 0, 0, 0, 0, 0, 0);
      n0 = trig_total;
      push(50, k); pushn(60, 4);
      chk(trig_total == n0, "R2", "first sample above threshold", trig_total - n0, 0);
      apply(0, 0, 0, 0, 0, 0, 0);
      n0 = trig_total;
      push(-1, k); push(0, k); pushn(0, 3);
      chk(trig_total - n0 == 1 && last_trig == k + 1, "R2", "reaching threshold exactly", last_trig, k + 1);
      apply(0, 1, 0, 0, 0, 0, 0);
      n0 = trig_total;
      push(50, k); push(-50, k); pushn(-50, 3);
      chk(trig_total - n0 == 1 && last_trig == k + 1, "R2", "falling crossing cycle", last_trig, k + 1);
   endtask

   task automatic t_hyst;
      int n0, k, kf;
      apply(1, 0, 100, 0, 50, 0, 0);
      n0 = trig_total;
      push(80, k); push(120, k); push(90, k); push(120, k);
      push(40, k); push(120, kf); pushn(120, 12);
      push(90, k); push(120, k); pushn(120, 3);
      chk(trig_total - n0 == 1, "R3", "rising hysteresis count", trig_total - n0, 1);
      chk(last_trig == kf + 1, "R3", "rising hysteresis cycle", last_trig, kf + 1);
      apply(1, 1, 100, 0, 50, 0, 0);
      n0 = trig_total;
      push(120, k); push(90, k); push(160, k); push(99, kf); pushn(99, 3);
      chk(trig_total - n0 == 1 && last_trig == kf + 1, "R3", "falling hysteresis cycle", last_trig, kf + 1);
   endtask

   task automatic t_window;
      int n0, k;
      apply(2, 0, 100, -100, 0, 0, 0);
      n0 = trig_total;
      push(200, k); push(-200, k); push(100, k); pushn(100, 3);
      chk(trig_total - n0 == 1 && last_trig == k + 1, "R4", "entering at upper bound", last_trig, k + 1);
      apply(2, 1, 100, -100, 0, 0, 0);
      n0 = trig_total;
      push(0, k); push(100, k); push(101, k); pushn(101, 3);
      chk(trig_total - n0 == 1 && last_trig == k + 1, "R4", "leaving above upper bound", last_trig, k + 1);
   endtask

   task automatic t_dead;
      int n0, k;
      apply(3, 0, 0, 0, 0, 3, 0);
      n0 = trig_total;
      push(0, k); pushn(0, 29);
      chk(trig_total - n0 == 3, "R10", "immediate pulses in 30 samples", trig_total - n0, 3);
      chk(last_trig - prev_trig == 10, "R10", "dead time spacing", last_trig - prev_trig, 10);
      chk(last_trig == k + 21, "R5", "immediate first pulse timing", last_trig, k + 21);
      chk(dbl == 0, "R8", "back-to-back high cycles", dbl, 0);
   endtask

   task automatic t_holdoff;
      int n0, k;
      apply(3, 0, 0, 0, 0, 25, 0);
      n0 = trig_total;
      push(0, k); pushn(0, 59);
      chk(trig_total - n0 == 3, "R11", "pulses with holdoff 25", trig_total - n0, 3);
      chk(last_trig - prev_trig == 25, "R11", "holdoff spacing", last_trig - prev_trig, 25);
   endtask

   task automatic t_soft;
      int n0, k;
      apply(4, 0, 0, 0, 0, 0, 0);
      n0 = trig_total;
      @(negedge clk); sw_trig = 1'b1; k = cyc + 1;
      @(negedge clk); sw_trig = 1'b0;
      gap(0, 4);
      chk(trig_total - n0 == 1 && last_trig == k + 1, "R6", "software pulse without valid", last_trig, k + 1);
   endtask

   task automatic t_invalid;
      int n0, k;
      apply(0, 0, 0, 0, 0, 0, 0);
      n0 = trig_total;
      push(-100, k); gap(100, 2); push(-100, k); pushn(-100, 3);
      chk(trig_total == n0, "R7", "invalid high sample ignored", trig_total - n0, 0);
      push(100, k); pushn(100, 3);
      chk(trig_total - n0 == 1 && last_trig == k + 1, "R7", "history kept across gap", last_trig, k + 1);
   endtask

   task automatic t_delay;
      int n0, k;
      apply(0, 0, 0, 0, 0, 0, 7);
      n0 = trig_total;
      push(-10, k); push(10, k); pushn(10, 12);
      chk(trig_total - n0 == 1 && last_trig == k + 8, "R9", "delay of 7", last_trig, k + 8);
      apply(0, 0, 0, 0, 0, 0, 4);
      n0 = trig_total;
      push(-10, k); push(10, k); pushn(10, 1); gap(10, 3); pushn(10, 8);
      chk(trig_total - n0 == 1 && last_trig == k + 8, "R9", "delay counts strobes only", last_trig, k + 8);
   endtask

   task automatic t_discard;
      int n0, k, k2;
      apply(0, 0, 0, 0, 0, 20, 0);
      n0 = trig_total;
      push(-10, k); push(10, k); push(-10, k2); push(10, k2); push(-10, k2); push(10, k2);
      pushn(10, 40);
      chk(trig_total - n0 == 1 && last_trig == k + 1, "R12", "crossings in block not queued", trig_total - n0, 1);
      push(-10, k2); push(10, k2); pushn(10, 3);
      chk(trig_total - n0 == 2 && last_trig == k2 + 1, "R12", "crossing after block fires", last_trig, k2 + 1);
   endtask

   task automatic t_wait_discard;
      int n0, k, kx;
      apply(0, 0, 0, 0, 0, 0, 20);
      n0 = trig_total;
      push(-10, k); push(10, k); push(-10, kx); push(10, kx); push(-10, kx); push(10, kx);
      pushn(10, 40);
      chk(trig_total - n0 == 1, "R13", "crossings during delay dropped", trig_total - n0, 1);
      chk(last_trig == k + 21, "R13", "pending pulse timing kept", last_trig, k + 21);
   endtask

   initial begin
      t_reset();
      t_edge();
      t_hyst();
      t_window();
      t_dead();
      t_holdoff();
      t_soft();
      t_invalid();
      t_delay();
      t_discard();
      t_wait_discard();
      chk(dbl == 0, "R8", "pulse width over whole run", dbl, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #2000000;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule